// File: doc/BRIEF.md
# Quad-Rate Burst SRAM Access Controller

This block is the access logic of a synchronous SRAM that has a write data path and a read data path kept apart, and that moves four data words per access. A single shared address bus carries both read and write addresses. The block decodes two active-low selects on each rising edge of the primary clock and settles conflicts between requests. It collects the four write beats across both clock phases under per-byte enables. It keeps every burst as one wide entry in a behavioural array. It hands every accepted read to the output stage as a single four-word item.

The double-rate data path is modelled with one fast clock `clk`, running at twice the primary rate, and an internal phase flag. Edges of `clk` alternate between primary edges and complementary edges, and the first edge after reset is a primary edge. The `prim_edge` output is high during the fast cycle that ends in a primary edge. Selects and address are sampled only on primary edges. Data beats and byte enables are sampled on every edge of a write burst.

The read result leaves as a valid-only stream, `rd_valid` with `rd_burst`. There is no back-pressure. The output stage must take each pulse in the fast cycle in which it is shown, because the array cannot stall a burst already in flight.

Top module: `qb_burst_sram_core`

## Requirements
- R1: `rd_sel_n` and `wr_sel_n` are active low and are sampled with `addr` only on primary edges. An accepted read returns the entry stored at `addr`.
- R2: When both selects are low on the same primary edge, the read is performed and the write is dropped. The write's address entry stays unchanged.
- R3: A request of the same type as the one accepted on the previous primary edge is dropped. A select held low therefore yields one accepted access every second primary cycle.
- R4: For a write accepted on primary edge P0, beat 0 is taken on P1, beat 1 on the complementary edge after P1, beat 2 on P2 and beat 3 on the complementary edge after P2. Beat k is stored in bits [k*DW+DW-1 : k*DW] of the entry, and `rd_burst` uses the same word order.
- R5: `wbe_n` is active low and is sampled with each beat. Bit l covers bits [9*l+8 : 9*l] of that beat. A masked lane keeps its previously stored nine bits.
- R6: Reads and writes may alternate on consecutive primary cycles, and after an idle primary cycle either type may start.
- R7: Each accepted read produces exactly one `rd_valid` pulse, one fast cycle long. The pulse is shown after the primary edge that comes RD_CYC primary cycles (2*RD_CYC fast edges) after the address edge.
- R8: Read data is taken from the array on the address edge. A read accepted on P1 or P2 after a write accepted on P0 to the same address returns the old entry, and a read on P3 or later returns the new one.
- R9: Reset clears the whole array to zero and holds `rd_valid` low.
- R10: `prim_edge` alternates every fast cycle and is high in the first fast cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the primary rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read request, active low |
| wr_sel_n | input | 1 | Write request, active low |
| addr | input | AW | Shared burst address |
| wdat | input | DW | Write data beat |
| wbe_n | input | DW/9 | Active-low byte-lane enables for the current beat |
| prim_edge | output | 1 | High when the next `clk` edge is a primary edge |
| rd_valid | output | 1 | One-cycle pulse, read burst available |
| rd_burst | output | 4*DW | Four read words, word 0 in the low bits |

## Verification
The bench sets simultaneous and back-to-back requests against each other. If the arbitration were wrong, a read would go missing, an extra read pulse would appear, or a dropped write would change an entry that later reads back as nonzero. Masked writes with a different lane pattern on each beat show up any swap of beats, lanes or enable polarity. Reads placed one, two and three primary cycles after a write to the same address mark the exact point where the new data becomes visible. A design that commits a cycle early or reads late returns the wrong generation of data. Every pulse is also checked against its expected fast-cycle time, so an extra or missing pipeline stage is reported even when the data is correct.

// File: rtl/qb_pkg.sv
package qb_pkg;
  // width of one byte lane, including its ninth (check) bit
  localparam int unsigned LANE_W = 9;
  // words per burst
  localparam int unsigned BEATS  = 4;
endpackage

// File: rtl/qb_req_arb.sv
module qb_req_arb #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  output logic          prim,
  output logic          rd_acc,
  output logic          wr_acc,
  output logic          wr_prev,
  output logic [AW-1:0] wr_addr_q
);
  logic ph;
  logic rd_prev;

  // phase 0 means the coming edge is a primary edge
  assign prim   = ~ph;
  // a read wins whenever it is requested; repeats on adjacent cycles drop
  assign rd_acc = prim & ~rd_sel_n & ~rd_prev;
  assign wr_acc = prim & ~wr_sel_n & rd_sel_n & ~wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      rd_prev   <= 1'b0;
      wr_prev   <= 1'b0;
      wr_addr_q <= '0;
    end else begin
      ph <= ~ph;
      if (prim) begin
        rd_prev <= rd_acc;
        wr_prev <= wr_acc;
        if (wr_acc) wr_addr_q <= addr;
      end
    end
  end
endmodule

// File: rtl/qb_wr_cap.sv
module qb_wr_cap
  import qb_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 6,
  localparam int unsigned LN = DW / LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prim,
  input  logic               start,
  input  logic [AW-1:0]      start_addr,
  input  logic [DW-1:0]      din,
  input  logic [LN-1:0]      din_be_n,
  output logic               mem_we,
  output logic [AW-1:0]      mem_waddr,
  output logic [BEATS*DW-1:0] mem_wdata,
  output logic [BEATS*LN-1:0] mem_wbe
);
  logic [DW-1:0] wbuf [BEATS];
  logic [LN-1:0] bbuf [BEATS];
  logic [1:0]    idx;
  logic          act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < int'(BEATS); b++) begin
        wbuf[b] <= '0;
        bbuf[b] <= '0;
      end
      idx       <= '0;
      act       <= 1'b0;
      mem_waddr <= '0;
    end else if (prim && start) begin
      // first beat arrives on the primary edge after the address edge
      wbuf[0]   <= din;
      bbuf[0]   <= ~din_be_n;
      idx       <= 2'd1;
      act       <= 1'b1;
      mem_waddr <= start_addr;
    end else if (act) begin
      wbuf[idx] <= din;
      bbuf[idx] <= ~din_be_n;
      idx       <= idx + 2'd1;
      if (idx == 2'd3) act <= 1'b0;
    end
  end

  // the last beat goes straight to the array on its own edge
  assign mem_we = act & (idx == 2'd3);

  for (genvar w = 0; w < int'(BEATS); w++) begin : g_beat
    if (w == int'(BEATS) - 1) begin : g_last
      assign mem_wdata[w*DW +: DW] = din;
      assign mem_wbe[w*LN +: LN]   = ~din_be_n;
    end else begin : g_held
      assign mem_wdata[w*DW +: DW] = wbuf[w];
      assign mem_wbe[w*LN +: LN]   = bbuf[w];
    end
  end
endmodule

// File: rtl/qb_burst_mem.sv
module qb_burst_mem
  import qb_pkg::*;
#(
  parameter int unsigned WW  = 72,
  parameter int unsigned AW  = 6,
  parameter int unsigned NBE = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [WW-1:0]  wdata,
  input  logic [NBE-1:0] wbe,
  input  logic [AW-1:0]  raddr,
  output logic [WW-1:0]  rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      for (int l = 0; l < int'(NBE); l++) begin
        if (wbe[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qb_rd_pipe.sv
module qb_rd_pipe #(
  parameter int unsigned WW  = 72,
  parameter int unsigned LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [WW-1:0] in_d,
  output logic          out_v,
  output logic [WW-1:0] out_d
);
  logic          v [LEN];
  logic [WW-1:0] d [LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(LEN); s++) begin
        v[s] <= 1'b0;
        d[s] <= '0;
      end
    end else begin
      v[0] <= in_v;
      d[0] <= in_d;
      for (int s = 1; s < int'(LEN); s++) begin
        v[s] <= v[s-1];
        d[s] <= d[s-1];
      end
    end
  end

  assign out_v = v[LEN-1];
  assign out_d = d[LEN-1];
endmodule

// File: rtl/qb_burst_sram_core.sv
module qb_burst_sram_core
  import qb_pkg::*;
#(
  parameter int unsigned DW     = 18,
  parameter int unsigned AW     = 6,
  parameter int unsigned RD_CYC = 1,
  localparam int unsigned LN    = DW / LANE_W,
  localparam int unsigned WW    = BEATS * DW,
  localparam int unsigned NBE   = BEATS * LN,
  localparam int unsigned PLEN  = 2 * RD_CYC + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdat,
  input  logic [LN-1:0] wbe_n,
  output logic          prim_edge,
  output logic          rd_valid,
  output logic [WW-1:0] rd_burst
);
  logic           rd_acc, wr_acc, wr_prev;
  logic [AW-1:0]  wr_addr_q;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr;
  logic [WW-1:0]  mem_wdata, mem_rdata;
  logic [NBE-1:0] mem_wbe;

  qb_req_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .prim(prim_edge), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .wr_prev(wr_prev), .wr_addr_q(wr_addr_q)
  );

  qb_wr_cap #(.DW(DW), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .prim(prim_edge), .start(wr_prev),
    .start_addr(wr_addr_q), .din(wdat), .din_be_n(wbe_n),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_wbe(mem_wbe)
  );

  qb_burst_mem #(.WW(WW), .AW(AW), .NBE(NBE)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .wbe(mem_wbe), .raddr(addr), .rdata(mem_rdata)
  );

  qb_rd_pipe #(.WW(WW), .LEN(PLEN)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(rd_acc), .in_d(mem_rdata),
    .out_v(rd_valid), .out_d(rd_burst)
  );
endmodule

// File: rtl/qb_burst_sram_core_chk.sv
module qb_burst_sram_core_chk (
  input logic clk,
  input logic rst_n,
  input logic prim,
  input logic rd_acc,
  input logic wr_acc,
  input logic mem_we,
  input logic rd_valid
);
  p_read_on_prim_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> prim);
  p_read_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> !wr_acc);
  p_rd_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> ##1 !rd_acc);
  p_wr_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> ##1 !wr_acc);
  p_commit_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_acc, 5));
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_valid_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !prim);
  p_phase_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prim |=> !prim);
  p_phase_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !prim |=> prim);
endmodule

bind qb_burst_sram_core qb_burst_sram_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prim(prim_edge), .rd_acc(rd_acc),
  .wr_acc(wr_acc), .mem_we(mem_we), .rd_valid(rd_valid)
);

// File: tb/qb_burst_sram_core_tb.sv
module qb_burst_sram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int RD_CYC = 1;
  localparam int LN = DW / 9;
  localparam int WW = 4 * DW;
  localparam logic [LN-1:0] FM = '0;
  localparam logic [LN-1:0] NM = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0;
  logic [LN-1:0] wbe_n = '1;
  logic          prim_edge, rd_valid;
  logic [WW-1:0] rd_burst;

  int checks = 0, errors = 0, tick = 0;

  typedef struct {
    logic [WW-1:0] data;
    int            due;
    string         tag;
  } exp_t;
  exp_t expq[$];

  // bench-side model of the requirements
  logic [WW-1:0] mm [1 << AW];
  logic          m_rd_prev = 0, m_wr_prev = 0, m_pend = 0, m_cap_on = 0;
  logic [AW-1:0] m_pend_a = '0, m_cap_a = '0;
  logic [DW-1:0] mb [4];
  logic [LN-1:0] mk [4];

  qb_burst_sram_core #(.DW(DW), .AW(AW), .RD_CYC(RD_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdat(wdat), .wbe_n(wbe_n), .prim_edge(prim_edge),
    .rd_valid(rd_valid), .rd_burst(rd_burst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mkw(input int seed, input int k);
    return {seed[7:0], k[1:0], 8'hA5};
  endfunction

  // one primary cycle: two fast cycles, inputs applied at the negedge
  task automatic cyc(input logic rn, input logic wn, input logic [AW-1:0] a,
                     input logic [DW-1:0] d0, input logic [LN-1:0] m0,
                     input logic [DW-1:0] d1, input logic [LN-1:0] m1,
                     input string tag);
    exp_t e;
    logic r_ok, w_ok;
    rd_sel_n = rn; wr_sel_n = wn; addr = a; wdat = d0; wbe_n = m0;
    r_ok = !rn && !m_rd_prev;
    w_ok = !wn && rn && !m_wr_prev;
    if (r_ok) begin
      e.data = mm[a]; e.due = tick + 1 + 2*RD_CYC; e.tag = tag;
      expq.push_back(e);
    end
    if (m_cap_on) begin
      mb[2] = d0; mk[2] = m0; mb[3] = d1; mk[3] = m1;
      for (int w = 0; w < 4; w++)
        for (int l = 0; l < LN; l++)
          if (!mk[w][l]) mm[m_cap_a][w*DW + l*9 +: 9] = mb[w][l*9 +: 9];
      m_cap_on = 0;
    end
    if (m_pend) begin
      m_cap_a = m_pend_a; mb[0] = d0; mk[0] = m0; mb[1] = d1; mk[1] = m1;
      m_cap_on = 1;
    end
    m_pend = w_ok; m_pend_a = a; m_rd_prev = r_ok; m_wr_prev = w_ok;
    @(negedge clk);
    wdat = d1; wbe_n = m1;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(1, 1, '0, '0, NM, '0, NM, tag);
  endtask

  // monitor: pops expectations as pulses come out
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        check(0, "R7 unexpected pulse", rd_burst, '0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rd_burst == e.data, e.tag, rd_burst, e.data);
        check(tick == e.due, {e.tag, " R7 latency"}, WW'(tick), WW'(e.due));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R9 valid low in reset", WW'(rd_valid), '0);
    rst_n = 1'b1;
    check(prim_edge == 1'b1, "R10 first edge primary", WW'(prim_edge), WW'(1));
    // R9: zero after reset; R1 read path
    cyc(0, 1, 6'd3, '0, NM, '0, NM, "R9 zero read");
    idle("-");
    // R4 / R1: full write then read back
    cyc(1, 0, 6'd5, '0, NM, '0, NM, "R4");
    cyc(1, 1, '0, mkw(1,0), FM, mkw(1,1), FM, "R4");
    cyc(1, 1, '0, mkw(1,2), FM, mkw(1,3), FM, "R4");
    cyc(0, 1, 6'd5, '0, NM, '0, NM, "R1 R4 full burst");
    idle("-");
    // R5: different lane mask per beat
    cyc(1, 0, 6'd5, '0, NM, '0, NM, "R5");
    cyc(1, 1, '0, mkw(2,0), 2'b01, mkw(2,1), 2'b10, "R5");
    cyc(1, 1, '0, mkw(2,2), 2'b11, mkw(2,3), 2'b00, "R5");
    cyc(0, 1, 6'd5, '0, NM, '0, NM, "R5 masked lanes");
    idle("-");
    // R2: read and write together, write must be dropped
    cyc(0, 0, 6'd9, '0, NM, '0, NM, "R2 read wins");
    cyc(1, 1, '0, mkw(3,0), FM, mkw(3,1), FM, "R2");
    cyc(1, 1, '0, mkw(3,2), FM, mkw(3,3), FM, "R2");
    cyc(0, 1, 6'd9, '0, NM, '0, NM, "R2 write dropped");
    idle("-");
    // R3: read select held low for four cycles
    cyc(0, 1, 6'd10, '0, NM, '0, NM, "R3 held read");
    cyc(0, 1, 6'd11, '0, NM, '0, NM, "R3 held read");
    cyc(0, 1, 6'd5,  '0, NM, '0, NM, "R3 held read");
    cyc(0, 1, 6'd13, '0, NM, '0, NM, "R3 held read");
    idle("-");
    // R3: write select held low, second write dropped
    cyc(1, 0, 6'd20, '0, NM, '0, NM, "R3");
    cyc(1, 0, 6'd21, mkw(4,0), FM, mkw(4,1), FM, "R3");
    cyc(1, 1, '0, mkw(4,2), FM, mkw(4,3), FM, "R3");
    cyc(0, 1, 6'd20, '0, NM, '0, NM, "R3 first write kept");
    idle("-");
    cyc(0, 1, 6'd21, '0, NM, '0, NM, "R3 repeat write dropped");
    idle("-");
    // R6: alternating writes and reads
    cyc(1, 0, 6'd30, '0, NM, '0, NM, "R6");
    cyc(0, 1, 6'd5, mkw(5,0), FM, mkw(5,1), FM, "R6 interleaved read");
    cyc(1, 0, 6'd31, mkw(5,2), FM, mkw(5,3), FM, "R6");
    cyc(0, 1, 6'd30, mkw(6,0), FM, mkw(6,1), FM, "R6 interleaved read");
    cyc(1, 1, '0, mkw(6,2), FM, mkw(6,3), FM, "R6");
    cyc(0, 1, 6'd31, '0, NM, '0, NM, "R6 read after idle");
    idle("-");
    // R8: read during the write burst returns old data
    cyc(1, 0, 6'd40, '0, NM, '0, NM, "R8");
    cyc(0, 1, 6'd40, mkw(7,0), FM, mkw(7,1), FM, "R8 old data P1");
    cyc(1, 1, '0, mkw(7,2), FM, mkw(7,3), FM, "R8");
    cyc(0, 1, 6'd40, '0, NM, '0, NM, "R8 new data P3");
    idle("-");
    cyc(1, 0, 6'd41, '0, NM, '0, NM, "R8");
    cyc(1, 1, '0, mkw(8,0), FM, mkw(8,1), FM, "R8");
    cyc(0, 1, 6'd41, mkw(8,2), FM, mkw(8,3), FM, "R8 old data P2");
    idle("-");
    cyc(0, 1, 6'd41, '0, NM, '0, NM, "R8 new data P4");
    repeat (4) idle("-");
    check(expq.size() == 0, "R7 every read pulsed", WW'(expq.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule